// File: doc/BRIEF.md
# Clock Source Selection Controller

This block is the control core of a multi-source clock generator. Software asks for an output clock source, which can be the internal reference, the external reference or the locked loop. It also asks for the reference that feeds the loop, the loop type (frequency-locked or phase-locked), a low-power setting and a bus divide ratio. The block keeps each request apart from the selection that is actually in force. A change of selection takes place only on a reference tick, and only once the source asked for is known to be ready. Two status outputs report the source and the reference actually in use.

No real clocks are switched. Each source is represented by a one-cycle clock-enable strobe, and the block selects, divides or gates these strobes. Stop mode freezes the selection and silences every generated strobe, except the two reference outputs whose run-in-stop conditions are met. When debug becomes active while low power is requested, the block keeps the loop running and moves the output onto the external reference. Readiness of each source and the loop lock arrive as asynchronous flags and pass through a two-stage synchronizer.

Top module: `clk_source_ctrl`

## Requirements
- R1: After reset, srcStat reads 1 (internal reference), refStat reads 1 (internal reference) and lockStat reads 0.
- R2: Source codes are 0 = loop, 1 = internal reference, 2 = external reference. The selection takes the effective request on a cycle with refTick high and stopMode low, and only if the requested source is ready. The internal and external sources are ready when their flag has passed two synchronizer stages. The loop is ready when lockStat is 1. srcStat shows the new selection one cycle after the selection register changes.
- R3: A request for a source that is not ready, or for code 3, leaves srcStat unchanged.
- R4: refSelInt (1 = internal reference, 0 = external) is accepted on a refTick once the chosen reference is ready, and refStat follows one cycle later. Accepting the change clears lockStat. lockStat returns only after the synchronized loop lock flag has been seen low and then high again.
- R5: rangeErr is 1 when the requested reference frequency, divided by 2^refDiv, falls outside 31.25 kHz to 39.0625 kHz with loopIsPll = 0, or outside 1 MHz to 2 MHz with loopIsPll = 1.
- R6: While stopMode is 1, outTick and busTick stay 0, loopOn is 0 and the selection does not change. intRefTick passes intTickIn only when intEn is 1 and (stopMode is 0 or intStopEn is 1). extRefTick follows the same rule with extTickIn, extEn and extStopEn.
- R7: With lowPower = 1 and debugActive = 0, loopOn is 0, lockStat is cleared in the next cycle and dbgClkAvail is 0. dbgClkAvail is 1 only when lockStat and loopOn are both 1.
- R8: With lowPower = 1 and debugActive = 1, the effective source request is the external reference whatever srcReq holds, and loopOn is 1 unless stopMode is 1.
- R9: busTick is outTick qualified so that it passes one outTick in 2^busDivSel (busDivSel 0..3 gives divide by 1, 2, 4, 8). It is counted by a counter that advances on each outTick, and a new busDivSel applies in the same cycle.
- R10: outTick equals the tick input of the selected source (loopTickIn also needs loopOn), forced to 0 in stop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcReq | input | 2 | Requested output source code |
| refSelInt | input | 1 | Requested loop reference, 1 = internal |
| loopIsPll | input | 1 | Loop type, 1 = phase-locked |
| lowPower | input | 1 | Low-power request, disables loop |
| refDiv | input | 3 | Reference divide exponent |
| busDivSel | input | 2 | Bus divide exponent |
| intEn | input | 1 | Internal reference output enable |
| intStopEn | input | 1 | Internal reference keeps running in stop |
| extEn | input | 1 | External reference output enable |
| extStopEn | input | 1 | External reference keeps running in stop |
| stopMode | input | 1 | Device in stop state |
| debugActive | input | 1 | Debug session active |
| intAvail | input | 1 | Internal reference ready (async) |
| extAvail | input | 1 | External reference ready (async) |
| loopLocked | input | 1 | Loop lock indication (async) |
| refTick | input | 1 | Reference tick, switch boundary |
| intTickIn | input | 1 | Internal reference clock enable |
| extTickIn | input | 1 | External reference clock enable |
| loopTickIn | input | 1 | Loop output clock enable |
| srcStat | output | 2 | Source actually in use |
| refStat | output | 1 | Reference actually in use |
| lockStat | output | 1 | Qualified loop lock |
| loopOn | output | 1 | Loop enabled |
| dbgClkAvail | output | 1 | Loop-derived debug clock available |
| rangeErr | output | 1 | Divided reference outside loop range |
| outTick | output | 1 | Selected output clock enable |
| busTick | output | 1 | Divided bus clock enable |
| intRefTick | output | 1 | Gated internal reference enable |
| extRefTick | output | 1 | Gated external reference enable |

## Verification
The bench requests sources that are not ready and the reserved code, and checks that srcStat stays put. A design that switched without checking readiness would report a source that is not running. It flips the reference while the loop is locked and expects lockStat to stay low until the lock flag toggles. A design that skipped relock would claim lock on a stale loop. It enters stop with each combination of enable and stop-enable bits, which catches reference gates that ignore one of the two bits. It enters debug under low power with an internal-reference request. A design missing the fallback would keep the loop off and the output on the internal reference. Bus divide changes in the middle of a count show whether the new ratio applies at once.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  typedef enum logic [1:0] {
    SRC_LOOP = 2'd0,
    SRC_INT  = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_RSVD = 2'd3
  } src_e;

  typedef struct packed {
    src_e srcSel;
    logic loopOn;
    logic stopped;
  } ctrl_strobe_t;
endpackage

// File: rtl/clksel_sync.sv
module clksel_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else if (s == 0) stageQ[s] <= asyncIn;
        else stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   srcReq,
  input  logic         refSelInt,
  input  logic         lowPower,
  input  logic         stopMode,
  input  logic         debugActive,
  input  logic         intAvail,
  input  logic         extAvail,
  input  logic         loopLocked,
  input  logic         refTick,
  output ctrl_strobe_t strobes,
  output logic [1:0]   srcStat,
  output logic         refStat,
  output logic         lockStat,
  output logic         dbgClkAvail
);
  logic [2:0] syncVec;
  logic intRdy, extRdy, lockRdy;
  src_e srcSel, srcStatQ, effReq;
  logic refSel;
  logic needRelock;
  logic lpEff, loopOn;
  logic reqRdy, refRdy, boundary, srcSwitch, refSwitch;

  clksel_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({loopLocked, extAvail, intAvail}),
    .syncOut(syncVec)
  );
  assign intRdy  = syncVec[0];
  assign extRdy  = syncVec[1];
  assign lockRdy = syncVec[2];

  assign lpEff  = lowPower && !debugActive;
  assign loopOn = !stopMode && !lpEff;

  always_comb begin
    if (lowPower && debugActive) effReq = SRC_EXT;
    else effReq = src_e'(srcReq);
    case (effReq)
      SRC_LOOP: reqRdy = lockStat;
      SRC_INT:  reqRdy = intRdy;
      SRC_EXT:  reqRdy = extRdy;
      default:  reqRdy = 1'b0;
    endcase
  end

  assign refRdy    = refSelInt ? intRdy : extRdy;
  assign boundary  = refTick && !stopMode;
  assign srcSwitch = boundary && (effReq != srcSel) && reqRdy;
  assign refSwitch = boundary && (refSelInt != refSel) && refRdy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel   <= SRC_INT;
      srcStatQ <= SRC_INT;
      refSel   <= 1'b1;
      refStat  <= 1'b1;
    end else begin
      srcStatQ <= srcSel;
      refStat  <= refSel;
      if (srcSwitch) srcSel <= effReq;
      if (refSwitch) refSel <= refSelInt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockStat   <= 1'b0;
      needRelock <= 1'b0;
    end else if (!loopOn || refSwitch) begin
      lockStat   <= 1'b0;
      needRelock <= 1'b1;
    end else begin
      if (!lockRdy) needRelock <= 1'b0;
      lockStat <= lockRdy && !needRelock;
    end
  end

  assign srcStat     = srcStatQ;
  assign dbgClkAvail = lockStat && loopOn;

  always_comb begin
    strobes.srcSel  = srcSel;
    strobes.loopOn  = loopOn;
    strobes.stopped = stopMode;
  end

  a_r2_switch_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel != $past(srcSel)) |-> $past(refTick && !stopMode));
  a_r6_stop_frozen: assert property (@(posedge clk) disable iff (!rstN)
    stopMode |=> (srcSel == $past(srcSel)));
  a_r7_lp_clears_lock: assert property (@(posedge clk) disable iff (!rstN)
    (lowPower && !debugActive) |=> !lockStat);
  a_r4_relock_after_ref: assert property (@(posedge clk) disable iff (!rstN)
    refSwitch |=> !lockStat);
  a_r3_rsvd_never_taken: assert property (@(posedge clk) disable iff (!rstN)
    srcSel != SRC_RSVD);
endmodule

// File: rtl/clksel_dp.sv
module clksel_dp
  import clksel_pkg::*;
#(
  parameter int          BUSDIV_W = 2,
  parameter int          REFDIV_W = 3,
  parameter int unsigned INT_HZ   = 32768,
  parameter int unsigned EXT_HZ   = 4000000
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strobes,
  input  logic                refSelInt,
  input  logic                loopIsPll,
  input  logic [REFDIV_W-1:0] refDiv,
  input  logic [BUSDIV_W-1:0] busDivSel,
  input  logic                intEn,
  input  logic                intStopEn,
  input  logic                extEn,
  input  logic                extStopEn,
  input  logic                intTickIn,
  input  logic                extTickIn,
  input  logic                loopTickIn,
  output logic                outTick,
  output logic                busTick,
  output logic                intRefTick,
  output logic                extRefTick,
  output logic                rangeErr
);
  localparam int CNT_W = (1 << BUSDIV_W) - 1;
  localparam longint unsigned FLL_LO2 = 62500;
  localparam longint unsigned FLL_HI2 = 78125;
  localparam longint unsigned PLL_LO  = 1000000;
  localparam longint unsigned PLL_HI  = 2000000;

  logic selTick;
  logic [CNT_W-1:0] busCnt, busMask;
  longint unsigned refHz, divHz;

  always_comb begin
    case (strobes.srcSel)
      SRC_LOOP: selTick = loopTickIn && strobes.loopOn;
      SRC_INT:  selTick = intTickIn;
      SRC_EXT:  selTick = extTickIn;
      default:  selTick = 1'b0;
    endcase
  end
  assign outTick = selTick && !strobes.stopped;

  assign busMask = CNT_W'((1 << busDivSel) - 1);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busCnt <= '0;
    else if (outTick) busCnt <= busCnt + 1'b1;
  end
  assign busTick = outTick && ((busCnt & busMask) == '0);

  assign intRefTick = intTickIn && intEn && (!strobes.stopped || intStopEn);
  assign extRefTick = extTickIn && extEn && (!strobes.stopped || extStopEn);

  always_comb begin
    refHz = refSelInt ? longint'(INT_HZ) : longint'(EXT_HZ);
    divHz = refHz >> refDiv;
    if (loopIsPll) rangeErr = (divHz < PLL_LO) || (divHz > PLL_HI);
    else rangeErr = ((divHz << 1) < FLL_LO2) || ((divHz << 1) > FLL_HI2);
  end

  a_r9_bus_within_out: assert property (@(posedge clk) disable iff (!rstN)
    busTick |-> outTick);
  a_r6_bus_quiet_in_stop: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stopped |-> !busTick);
  a_r6_int_gate: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stopped && !intStopEn) |-> !intRefTick);
  a_r6_ext_gate: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stopped && !extStopEn) |-> !extRefTick);
endmodule

// File: rtl/clk_source_ctrl.sv
module clk_source_ctrl
  import clksel_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          BUSDIV_W    = 2,
  parameter int          REFDIV_W    = 3,
  parameter int unsigned INT_HZ      = 32768,
  parameter int unsigned EXT_HZ      = 4000000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          srcReq,
  input  logic                refSelInt,
  input  logic                loopIsPll,
  input  logic                lowPower,
  input  logic [REFDIV_W-1:0] refDiv,
  input  logic [BUSDIV_W-1:0] busDivSel,
  input  logic                intEn,
  input  logic                intStopEn,
  input  logic                extEn,
  input  logic                extStopEn,
  input  logic                stopMode,
  input  logic                debugActive,
  input  logic                intAvail,
  input  logic                extAvail,
  input  logic                loopLocked,
  input  logic                refTick,
  input  logic                intTickIn,
  input  logic                extTickIn,
  input  logic                loopTickIn,
  output logic [1:0]          srcStat,
  output logic                refStat,
  output logic                lockStat,
  output logic                loopOn,
  output logic                dbgClkAvail,
  output logic                rangeErr,
  output logic                outTick,
  output logic                busTick,
  output logic                intRefTick,
  output logic                extRefTick
);
  ctrl_strobe_t strobes;

  clksel_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .srcReq     (srcReq),
    .refSelInt  (refSelInt),
    .lowPower   (lowPower),
    .stopMode   (stopMode),
    .debugActive(debugActive),
    .intAvail   (intAvail),
    .extAvail   (extAvail),
    .loopLocked (loopLocked),
    .refTick    (refTick),
    .strobes    (strobes),
    .srcStat    (srcStat),
    .refStat    (refStat),
    .lockStat   (lockStat),
    .dbgClkAvail(dbgClkAvail)
  );

  clksel_dp #(
    .BUSDIV_W(BUSDIV_W), .REFDIV_W(REFDIV_W), .INT_HZ(INT_HZ), .EXT_HZ(EXT_HZ)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .refSelInt (refSelInt),
    .loopIsPll (loopIsPll),
    .refDiv    (refDiv),
    .busDivSel (busDivSel),
    .intEn     (intEn),
    .intStopEn (intStopEn),
    .extEn     (extEn),
    .extStopEn (extStopEn),
    .intTickIn (intTickIn),
    .extTickIn (extTickIn),
    .loopTickIn(loopTickIn),
    .outTick   (outTick),
    .busTick   (busTick),
    .intRefTick(intRefTick),
    .extRefTick(extRefTick),
    .rangeErr  (rangeErr)
  );

  assign loopOn = strobes.loopOn;
endmodule

// File: tb/clk_source_ctrl_test.sv
module clk_source_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] srcReq = 2'd1;
  logic refSelInt = 1'b1, loopIsPll = 1'b0, lowPower = 1'b0;
  logic [2:0] refDiv = 3'd0;
  logic [1:0] busDivSel = 2'd1;
  logic intEn = 0, intStopEn = 0, extEn = 0, extStopEn = 0;
  logic stopMode = 0, debugActive = 0;
  logic intAvail = 0, extAvail = 0, loopLocked = 0, refTick = 0;
  logic intTickIn = 0, extTickIn = 0, loopTickIn = 0;
  logic [1:0] srcStat;
  logic refStat, lockStat, loopOn, dbgClkAvail, rangeErr;
  logic outTick, busTick, intRefTick, extRefTick;

  int checks = 0, failures = 0, cycles = 0;
  bit chkEn = 0;

  clk_source_ctrl uut (.*);

  always #10 clk = ~clk;

  // bench model state
  logic mI1, mI2, mE1, mE2, mL1, mL2;
  logic [1:0] mSel, mStat;
  logic mRef, mRefStat, mLock, mNeed;
  logic [2:0] mCnt;

  function automatic logic loopOnF(logic st, logic lp, logic dbg);
    return !st && !(lp && !dbg);
  endfunction
  function automatic logic [1:0] effF(logic [1:0] rq, logic lp, logic dbg);
    return (lp && dbg) ? 2'd2 : rq;
  endfunction
  function automatic logic rdyF(logic [1:0] s, logic i, logic e, logic l);
    case (s)
      2'd0: return l;
      2'd1: return i;
      2'd2: return e;
      default: return 1'b0;
    endcase
  endfunction
  function automatic logic rangeF(logic ri, logic pll, logic [2:0] dv);
    longint unsigned f = (ri ? 64'd32768 : 64'd4000000) >> dv;
    if (pll) return (f < 1000000) || (f > 2000000);
    return (2*f < 62500) || (2*f > 78125);
  endfunction
  function automatic logic outF();
    logic t;
    case (mSel)
      2'd0: t = loopTickIn && loopOnF(stopMode, lowPower, debugActive);
      2'd1: t = intTickIn;
      2'd2: t = extTickIn;
      default: t = 1'b0;
    endcase
    return t && !stopMode;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      {mI1, mI2, mE1, mE2, mL1, mL2} = '0;
      mSel = 2'd1; mStat = 2'd1; mRef = 1'b1; mRefStat = 1'b1;
      mLock = 0; mNeed = 0; mCnt = 0;
    end else begin
      logic lo, rsw, bnd, ot;
      logic [1:0] ef;
      lo  = loopOnF(stopMode, lowPower, debugActive);
      ef  = effF(srcReq, lowPower, debugActive);
      bnd = refTick && !stopMode;
      rsw = bnd && (refSelInt != mRef) && (refSelInt ? mI2 : mE2);
      ot  = outF();
      mStat = mSel;
      mRefStat = mRef;
      if (bnd && ef != mSel && rdyF(ef, mI2, mE2, mLock)) mSel = ef;
      if (rsw) mRef = refSelInt;
      if (!lo || rsw) begin mLock = 0; mNeed = 1; end
      else begin mLock = mL2 && !mNeed; if (!mL2) mNeed = 0; end
      if (ot) mCnt = mCnt + 1;
      mI2 = mI1; mI1 = intAvail;
      mE2 = mE1; mE1 = extAvail;
      mL2 = mL1; mL1 = loopLocked;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (chkEn) begin
      logic lo, ob;
      lo = loopOnF(stopMode, lowPower, debugActive);
      ob = outF();
      chk("R2 srcStat", srcStat, mStat);
      chk("R4 refStat", refStat, mRefStat);
      chk("R4 lockStat", lockStat, mLock);
      chk("R7 loopOn", loopOn, lo);
      chk("R7 dbgClkAvail", dbgClkAvail, mLock && lo);
      chk("R5 rangeErr", rangeErr, rangeF(refSelInt, loopIsPll, refDiv));
      chk("R10 outTick", outTick, ob);
      chk("R9 busTick", busTick, ob && ((mCnt & ((3'd1 << busDivSel) - 3'd1)) == 0));
      chk("R6 intRefTick", intRefTick, intTickIn && intEn && (!stopMode || intStopEn));
      chk("R6 extRefTick", extRefTick, extTickIn && extEn && (!stopMode || extStopEn));
    end
    if (cycles > 200000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      intTickIn  = $urandom_range(1, 0);
      extTickIn  = $urandom_range(1, 0);
      loopTickIn = $urandom_range(1, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    step(3);
    @(posedge clk); #2 rstN = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 srcStat reset", srcStat, 1);
    chk("R1 refStat reset", refStat, 1);
    chk("R1 lockStat reset", lockStat, 0);
    chkEn = 1;
    // R3: external not ready, reserved code
    refTick = 1; srcReq = 2'd2; step(10);
    chk("R3 unready source kept", srcStat, 1);
    srcReq = 2'd3; intAvail = 1; step(10);
    chk("R3 reserved code kept", srcStat, 1);
    // R2: external becomes ready
    srcReq = 2'd2; extAvail = 1; step(8);
    chk("R2 switch to external", srcStat, 2);
    // R4: lock, then reference change forces relock
    loopLocked = 1; refSelInt = 1; step(8);
    refSelInt = 0; step(3);
    chk("R4 lock dropped after ref switch", lockStat, 0);
    step(5);
    chk("R4 lock held low without toggle", lockStat, 0);
    loopLocked = 0; step(4); loopLocked = 1; step(6);
    chk("R4 relock after toggle", lockStat, 1);
    // R8: debug under low power forces external
    srcReq = 2'd1; step(6);
    lowPower = 1; debugActive = 1; step(6);
    chk("R8 forced external", srcStat, 2);
    chk("R8 loop kept on", loopOn, 1);
    debugActive = 0; step(3);
    chk("R7 low power lock cleared", lockStat, 0);
    lowPower = 0;
    // R6: stop with enable combinations
    intEn = 1; extEn = 1; intStopEn = 1; extStopEn = 0; stopMode = 1; step(20);
    intStopEn = 0; extStopEn = 1; step(20);
    stopMode = 0;
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(15, 0) == 0) srcReq = $urandom_range(3, 0);
      if ($urandom_range(31, 0) == 0) refSelInt = $urandom_range(1, 0);
      if ($urandom_range(31, 0) == 0) loopIsPll = $urandom_range(1, 0);
      if ($urandom_range(15, 0) == 0) refDiv = $urandom_range(7, 0);
      if ($urandom_range(15, 0) == 0) busDivSel = $urandom_range(3, 0);
      if ($urandom_range(63, 0) == 0) lowPower = $urandom_range(1, 0);
      if ($urandom_range(63, 0) == 0) debugActive = $urandom_range(1, 0);
      if ($urandom_range(63, 0) == 0) stopMode = $urandom_range(1, 0);
      if ($urandom_range(31, 0) == 0) intAvail = $urandom_range(1, 0);
      if ($urandom_range(31, 0) == 0) extAvail = $urandom_range(1, 0);
      if ($urandom_range(31, 0) == 0) loopLocked = $urandom_range(1, 0);
      if ($urandom_range(15, 0) == 0) {intEn, intStopEn, extEn, extStopEn} = $urandom_range(15, 0);
      refTick = ($urandom_range(3, 0) == 0);
      step(1);
    end
    step(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule